// File: doc/BRIEF.md
# Bit-Band Alias Bus Bridge

The bridge sits between a processor-side request/response port and a downstream memory port. Each aligned 32 MB alias window maps every 32-bit word it contains onto one bit of a smaller target region. A load through an alias word returns that bit alone, as 0 or 1. A store through an alias word sets or clears that bit and leaves every other target bit as it was.

A store is carried out downstream as a read of the target location, a mask update and a write-back of the same size. The two transfers are issued back to back, and a lock output is held across both so that no other master can reach the target between them. One bridge serves a parameterised set of windows, and each window has its own alias base and target base. By default there are two windows: alias 0x22000000 onto target 0x20000000, and alias 0x42000000 onto target 0x40000000.

The upstream master raises `up_valid` with stable request fields and holds it until `up_ready` pulses. The bridge captures the request on the first cycle and handles one request at a time.

Top module: `bb_alias_bridge`

## Requirements
- R1: An upstream address hits window k when its bits above bit 24 equal those of the alias base of window k. The lowest-numbered window wins when several match. With the defaults, 0x22xxxxxx and 0x23xxxxxx hit the window targeting 0x20000000, and 0x42xxxxxx and 0x43xxxxxx hit the window targeting 0x40000000.
- R2: The downstream address is the target base ORed with the low 25 alias address bits shifted right by 5. For halfword size bit 0 is then cleared, and for word size bits 1:0 are cleared. The downstream size equals the upstream size.
- R3: The size code is 0 for byte, 1 for halfword, 2 for word, and 3 is handled as word. The bit index is the alias address shifted right by 2, kept to 3, 4 or 5 bits by size. Downstream data is right-justified and little-endian: byte a+i occupies bits 8i+7:8i.
- R4: An alias read issues exactly one downstream read and returns the selected bit in up_rdata bit 0, with bits 31:1 zero.
- R5: An alias write issues one downstream read and then one write to the same address and size. The write data is the read value with the selected bit replaced by up_wdata bit 0. Bits 31:1 of up_wdata are ignored. An alias write responds with up_rdata zero.
- R6: dn_lock is high on both transfers of an alias write. It is low on the single transfer of an alias read.
- R7: up_ready is a one-cycle pulse issued only after the final downstream handshake. Upstream fields that change while a request is in flight do not affect it.
- R8: While dn_valid is high and dn_ready is low, dn_valid, dn_addr, dn_write and dn_size hold steady.
- R9: An address outside every window completes with an up_ready pulse and up_rdata zero, and issues no downstream transfer.
- R10: Synchronous active-low reset returns the bridge to idle, with dn_valid and up_ready low, including when a read-modify-write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Upstream request present |
| up_write | input | 1 | 1 = alias write, 0 = alias read |
| up_size | input | 2 | Access size code |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Write data (bit 0 used) |
| up_ready | output | 1 | One-cycle completion pulse |
| up_rdata | output | 32 | Read result, valid with up_ready |
| dn_valid | output | 1 | Downstream transfer request |
| dn_write | output | 1 | Downstream write when high |
| dn_lock | output | 1 | Holds the target between read and write-back |
| dn_size | output | 2 | Downstream size code |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data, right-justified |
| dn_rdata | input | 32 | Downstream read data, right-justified |
| dn_ready | input | 1 | Downstream transfer completes |

## Verification
The bench builds the bridge with its default two windows, so window priority decoding and both target bases are exercised. Its memory model adds one wait cycle to every downstream transfer. That stall makes the hold rule for downstream requests observable, and it gives the bench time to alter upstream fields while a request is in flight. The top bit of the word index is only reachable with word size, so word-size accesses cover bit 31, and halfword accesses cover the case where bit 0 of the address is cleared.

// File: rtl/bb_pkg.sv
// Package: shared encodings for the bit-band alias bridge.
// Assumes a 2-bit size code on both the upstream and downstream ports.
package bb_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2,
        ST_REPLY = 2'd3
    } rmw_state_e;

endpackage

// File: rtl/bb_alias_decode.sv
// Module: bb_alias_decode
// Combinational window match and translation from an alias address to a
// target address plus bit index. Assumes every alias window is aligned to
// 2**WIN_BITS bytes. When several windows match, the lowest index wins.
module bb_alias_decode
    import bb_pkg::*;
#(
    parameter int NUM_WIN  = 2,
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 25,
    parameter int BIDX_W   = 5,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] TGT_BASE   = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              hit,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [BIDX_W-1:0] bit_idx
);

    // One alias word per target bit: 4 bytes per bit, 8 bits per byte.
    localparam int SPAN_LG = 5;
    localparam logic [BIDX_W-1:0] MASK_BYTE = BIDX_W'(7);
    localparam logic [BIDX_W-1:0] MASK_HALF = BIDX_W'(15);
    localparam logic [BIDX_W-1:0] MASK_WORD = '1;

    logic [NUM_WIN-1:0]             win_hit;
    logic [NUM_WIN-1:0][ADDR_W-1:0] win_addr;
    logic [ADDR_W-1:0]              raw_addr;

    // Per-window compare and byte-address translation.
    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        assign win_hit[k]  = (addr[ADDR_W-1:WIN_BITS] == ALIAS_BASE[k][ADDR_W-1:WIN_BITS]);
        assign win_addr[k] = TGT_BASE[k] |
            ({{(ADDR_W-WIN_BITS){1'b0}}, addr[WIN_BITS-1:0]} >> SPAN_LG);
    end

    // Priority pick: scan downward so the lowest matching index is kept.
    always_comb begin
        hit      = 1'b0;
        raw_addr = '0;
        for (int k = NUM_WIN - 1; k >= 0; k--) begin
            if (win_hit[k]) begin
                hit      = 1'b1;
                raw_addr = win_addr[k];
            end
        end
    end

    // Size-dependent alignment of the target and masking of the bit index.
    always_comb begin
        tgt_addr = raw_addr;
        bit_idx  = addr[2 +: BIDX_W];
        case (size)
            SZ_BYTE: bit_idx = bit_idx & MASK_BYTE;
            SZ_HALF: begin
                tgt_addr[0] = 1'b0;
                bit_idx     = bit_idx & MASK_HALF;
            end
            default: begin
                tgt_addr[1:0] = 2'b00;
                bit_idx       = bit_idx & MASK_WORD;
            end
        endcase
    end

endmodule

// File: rtl/bb_rmw_engine.sv
// Module: bb_rmw_engine
// Sequencer that captures one upstream request, runs a single downstream
// read (alias read) or a locked read then write-back (alias write), and
// pulses the upstream ready. Assumes the upstream master holds its request
// until ready and drops it in the cycle after.
module bb_rmw_engine
    import bb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic              up_write,
    input  logic [1:0]        up_size,
    input  logic              up_wbit,
    input  logic              dec_hit,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic [BIDX_W-1:0] dec_bidx,
    output logic              up_ready,
    output logic [DATA_W-1:0] up_rdata,
    output logic              dn_valid,
    output logic              dn_write,
    output logic              dn_lock,
    output logic [1:0]        dn_size,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_ready
);

    rmw_state_e        state;
    logic              q_write;
    logic [1:0]        q_size;
    logic              q_wbit;
    logic [ADDR_W-1:0] q_addr;
    logic [BIDX_W-1:0] q_bidx;
    logic              q_bit;
    logic [DATA_W-1:0] q_wdata;
    logic [DATA_W-1:0] bit_mask;
    logic [DATA_W-1:0] merged;

    // Selected-bit mask and the updated word for the write-back.
    always_comb begin
        bit_mask = DATA_W'(1) << q_bidx;
        merged   = q_wbit ? (dn_rdata | bit_mask) : (dn_rdata & ~bit_mask);
    end

    // Sequencer state: capture, fetch, optional store, reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (up_valid) state <= dec_hit ? ST_FETCH : ST_REPLY;
                ST_FETCH: if (dn_ready) state <= q_write ? ST_STORE : ST_REPLY;
                ST_STORE: if (dn_ready) state <= ST_REPLY;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Request capture and data path registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_size  <= SZ_BYTE;
            q_wbit  <= 1'b0;
            q_addr  <= '0;
            q_bidx  <= '0;
            q_bit   <= 1'b0;
            q_wdata <= '0;
        end else if (state == ST_IDLE && up_valid) begin
            q_write <= up_write;
            q_size  <= up_size;
            q_wbit  <= up_wbit;
            q_addr  <= dec_addr;
            q_bidx  <= dec_bidx;
            q_bit   <= 1'b0;
        end else if (state == ST_FETCH && dn_ready) begin
            if (q_write) q_wdata <= merged;
            else         q_bit   <= dn_rdata[q_bidx];
        end
    end

    // Port drive decoded from the state.
    always_comb begin
        dn_valid = (state == ST_FETCH) || (state == ST_STORE);
        dn_write = (state == ST_STORE);
        dn_lock  = (state == ST_STORE) || (state == ST_FETCH && q_write);
        dn_size  = q_size;
        dn_addr  = q_addr;
        dn_wdata = q_wdata;
        up_ready = (state == ST_REPLY);
        up_rdata = {{(DATA_W-1){1'b0}}, q_bit};
    end

    // R7: the ready pulse lasts exactly one cycle.
    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |=> !up_ready);

    // R8: a stalled downstream request keeps its fields.
    assert_dn_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) &&
                                     $stable(dn_write) && $stable(dn_size)));

    // R6: a write-back starts only right after a locked, completed read.
    assert_store_after_locked_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_write && !$past(dn_valid && dn_write)) |->
            $past(dn_valid && !dn_write && dn_lock && dn_ready));

    // R4: read data carries at most bit 0.
    assert_read_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> (up_rdata[DATA_W-1:1] == '0));

    // R2: word-sized downstream transfers are word aligned.
    assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_size[1]) |-> (dn_addr[1:0] == 2'b00));

    // R10: the cycle after reset is idle on both ports.
    assert_idle_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!dn_valid && !up_ready));

endmodule

// File: rtl/bb_alias_bridge.sv
// Module: bb_alias_bridge (top)
// Bit-band alias bridge. The window decoder feeds the read-modify-write
// sequencer. Assumes aligned alias windows and a downstream port that
// returns right-justified little-endian data for the requested size.
module bb_alias_bridge #(
    parameter int NUM_WIN  = 2,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WIN_BITS = 25,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] TGT_BASE   = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    input  logic              up_write,
    input  logic [1:0]        up_size,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              up_ready,
    output logic [DATA_W-1:0] up_rdata,
    output logic              dn_valid,
    output logic              dn_write,
    output logic              dn_lock,
    output logic [1:0]        dn_size,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_ready
);

    localparam int BIDX_W = $clog2(DATA_W);

    logic              dec_hit;
    logic [ADDR_W-1:0] dec_addr;
    logic [BIDX_W-1:0] dec_bidx;
    logic              wdata_unused;

    // Only bit 0 of the write data selects set or clear.
    assign wdata_unused = ^up_wdata[DATA_W-1:1];

    bb_alias_decode #(
        .NUM_WIN    (NUM_WIN),
        .ADDR_W     (ADDR_W),
        .WIN_BITS   (WIN_BITS),
        .BIDX_W     (BIDX_W),
        .ALIAS_BASE (ALIAS_BASE),
        .TGT_BASE   (TGT_BASE)
    ) u_decode (
        .addr     (up_addr),
        .size     (up_size),
        .hit      (dec_hit),
        .tgt_addr (dec_addr),
        .bit_idx  (dec_bidx)
    );

    bb_rmw_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BIDX_W (BIDX_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (up_valid),
        .up_write (up_write),
        .up_size  (up_size),
        .up_wbit  (up_wdata[0]),
        .dec_hit  (dec_hit),
        .dec_addr (dec_addr),
        .dec_bidx (dec_bidx),
        .up_ready (up_ready),
        .up_rdata (up_rdata),
        .dn_valid (dn_valid),
        .dn_write (dn_write),
        .dn_lock  (dn_lock),
        .dn_size  (dn_size),
        .dn_addr  (dn_addr),
        .dn_wdata (dn_wdata),
        .dn_rdata (dn_rdata),
        .dn_ready (dn_ready)
    );

endmodule

// File: tb/test_bb_alias_bridge.sv
// Scoreboard bench for bb_alias_bridge. The driver pushes expected read
// results into a queue, and the monitor pops and compares them on each ready
// pulse. A byte-addressed memory model answers downstream transfers after
// one wait cycle.
module test_bb_alias_bridge;

    localparam int WAITS = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 1'b0;
    logic        up_write = 1'b0;
    logic [1:0]  up_size = 2'd0;
    logic [31:0] up_addr = '0;
    logic [31:0] up_wdata = '0;
    logic        up_ready;
    logic [31:0] up_rdata;
    logic        dn_valid, dn_write, dn_lock;
    logic [1:0]  dn_size;
    logic [31:0] dn_addr, dn_wdata;
    logic [31:0] dn_rdata = '0;
    logic        dn_ready = 1'b0;

    int tests = 0;
    int fails = 0;

    logic [7:0]  mem     [int unsigned];
    logic [7:0]  exp_mem [int unsigned];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    // Observations of downstream traffic for the current request.
    int          dn_cnt;
    bit          lock_and, lock_or;
    logic [31:0] rd_addr, wr_addr;
    logic [1:0]  rd_size, wr_size;
    int          wcnt = 0;

    always #4 clk = ~clk;

    bb_alias_bridge i_bb_alias_bridge (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_write(up_write), .up_size(up_size),
        .up_addr(up_addr), .up_wdata(up_wdata),
        .up_ready(up_ready), .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_lock(dn_lock),
        .dn_size(dn_size), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_rdata(dn_rdata), .dn_ready(dn_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [7:0] rd_byte(input bit use_exp, input int unsigned a);
        if (use_exp) return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    // R1/R2: expected window and target address, computed from the rules.
    function automatic logic [31:0] exp_tgt(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] t;
        t = ((a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000) | ({7'd0, a[24:0]} >> 5);
        if (sz == 2'd1) t[0] = 1'b0;
        if (sz[1])      t[1:0] = 2'b00;
        return t;
    endfunction

    // R3: expected bit index.
    function automatic int exp_bidx(input logic [31:0] a, input logic [1:0] sz);
        int raw = int'(a[6:2]);
        return (sz == 2'd0) ? (raw & 7) : (sz == 2'd1) ? (raw & 15) : raw;
    endfunction

    task automatic poke(input int unsigned a, input logic [7:0] v);
        mem[a] = v;
        exp_mem[a] = v;
    endtask

    // Downstream memory model: one wait cycle, then a handshake.
    always @(negedge clk) begin
        if (dn_ready) begin
            dn_ready = 1'b0;
        end else if (rst_n && dn_valid) begin
            if (wcnt < WAITS) begin
                wcnt++;
            end else begin
                wcnt = 0;
                dn_cnt++;
                lock_and = lock_and & dn_lock;
                lock_or  = lock_or | dn_lock;
                if (dn_write) begin
                    wr_addr = dn_addr;
                    wr_size = dn_size;
                    for (int i = 0; i < nbytes(dn_size); i++)
                        mem[dn_addr + i] = dn_wdata[8*i +: 8];
                end else begin
                    rd_addr = dn_addr;
                    rd_size = dn_size;
                    dn_rdata = '0;
                    for (int i = 0; i < nbytes(dn_size); i++)
                        dn_rdata[8*i +: 8] = rd_byte(0, dn_addr + i);
                end
                dn_ready = 1'b1;
            end
        end else begin
            wcnt = 0;
        end
    end

    // Monitor: compare every ready pulse against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && up_ready) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected ready", up_rdata, 32'hDEAD_BEEF);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, up_rdata, e);
            end
        end
    end

    // Driver: predict, push, run one request, then check downstream effects.
    task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, input bit disturb, input string tag);
        bit          hit;
        logic [31:0] t;
        int          b, n;
        logic [31:0] cur;
        hit = (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
        t = exp_tgt(a, sz);
        b = exp_bidx(a, sz);
        n = nbytes(sz);
        cur = '0;
        for (int i = 0; i < n; i++) cur[8*i +: 8] = rd_byte(1, t + i);
        if (hit && wr) begin
            int unsigned ba = t + b / 8;
            logic [7:0] v = rd_byte(1, ba);
            v[b % 8] = wd[0];
            exp_mem[ba] = v;
        end
        exp_q.push_back((hit && !wr) ? {31'd0, cur[b]} : 32'd0);
        tag_q.push_back(tag);
        dn_cnt = 0; lock_and = 1'b1; lock_or = 1'b0;
        rd_addr = '1; wr_addr = '1; rd_size = 2'd3; wr_size = 2'd3;
        @(negedge clk);
        up_valid = 1'b1; up_write = wr; up_size = sz; up_addr = a; up_wdata = wd;
        if (disturb) begin
            do @(negedge clk); while (!dn_valid);
            up_addr = a ^ 32'h0000_0F20; up_wdata = ~wd; up_size = ~sz; up_write = ~wr;
        end
        do @(negedge clk); while (!up_ready);
        up_valid = 1'b0;
        if (!hit) begin
            chk({"R9 no downstream: ", tag}, dn_cnt, 0);
        end else if (!wr) begin
            chk({"R4 one read: ", tag}, dn_cnt, 1);
            chk({"R2 read addr: ", tag}, rd_addr, t);
            chk({"R2 read size: ", tag}, {30'd0, rd_size}, {30'd0, sz});
            chk({"R6 read unlocked: ", tag}, {31'd0, lock_or}, 32'd0);
        end else begin
            chk({"R5 two transfers: ", tag}, dn_cnt, 2);
            chk({"R5 read addr: ", tag}, rd_addr, t);
            chk({"R5 write addr: ", tag}, wr_addr, t);
            chk({"R5 write size: ", tag}, {30'd0, wr_size}, {30'd0, sz});
            chk({"R6 locked: ", tag}, {31'd0, lock_and}, 32'd1);
            for (int i = 0; i < n; i++)
                chk({"R5 memory: ", tag}, {24'd0, rd_byte(0, t + i)}, {24'd0, rd_byte(1, t + i)});
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R7 watchdog: actual busy expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        poke(32'h2000_0004, 8'hA5); poke(32'h2000_0005, 8'h3C);
        poke(32'h2000_0006, 8'h81); poke(32'h2000_0007, 8'h7E);
        poke(32'h4000_0010, 8'h0F); poke(32'h4000_0011, 8'hF0);
        poke(32'h4000_0012, 8'h55); poke(32'h4000_0013, 8'hAA);
        repeat (3) @(negedge clk);
        // R10: idle during reset
        chk("R10 dn_valid in reset", {31'd0, dn_valid}, 32'd0);
        chk("R10 up_ready in reset", {31'd0, up_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 dn_valid after reset", {31'd0, dn_valid}, 32'd0);

        // R1 R3 R4: byte, halfword and word reads in window 0
        access(0, 2'd0, 32'h2200_0080, 0, 0, "R4 byte bit0");
        access(0, 2'd0, 32'h2200_0084, 0, 0, "R4 byte bit1");
        access(0, 2'd0, 32'h2200_009C, 0, 0, "R3 byte bit7");
        access(0, 2'd1, 32'h2200_00A4, 0, 0, "R3 half bit9 odd target");
        access(0, 2'd1, 32'h2200_00BC, 0, 0, "R3 half bit15");
        access(0, 2'd2, 32'h2200_00E4, 0, 0, "R3 word bit25");
        access(0, 2'd2, 32'h2200_00FC, 0, 0, "R3 word bit31");
        access(0, 2'd3, 32'h2200_00E0, 0, 0, "R3 size3 as word");
        access(0, 2'd0, 32'h2300_0000, 0, 0, "R1 upper half of window");

        // R5: set, clear with upper data bits set, read back
        access(1, 2'd0, 32'h2200_0084, 32'h0000_0001, 0, "R5 byte set");
        access(0, 2'd0, 32'h2200_0084, 0, 0, "R5 byte readback set");
        access(1, 2'd0, 32'h2200_0080, 32'hFFFF_FFFE, 0, "R5 clear ignores upper bits");
        access(0, 2'd0, 32'h2200_0080, 0, 0, "R5 byte readback clear");
        access(1, 2'd2, 32'h2200_00FC, 32'h1, 0, "R5 word set bit31");
        access(0, 2'd2, 32'h2200_00FC, 0, 0, "R5 word readback");
        access(1, 2'd1, 32'h2200_00A8, 32'h0, 0, "R5 half clear");

        // R1: second window
        access(0, 2'd0, 32'h4200_0200, 0, 0, "R1 window1 read");
        access(1, 2'd2, 32'h4200_0210, 32'h1, 0, "R1 window1 word set");
        access(0, 2'd2, 32'h4200_0210, 0, 0, "R1 window1 readback");

        // R9: misses
        access(0, 2'd2, 32'h3000_0000, 0, 0, "R9 miss read");
        access(1, 2'd0, 32'h2400_0080, 32'h1, 0, "R9 miss write");

        // R7 R8: upstream fields change while in flight
        access(1, 2'd0, 32'h2200_0098, 32'h1, 1, "R7 disturbed write");
        access(0, 2'd0, 32'h2200_0098, 0, 1, "R8 disturbed read");

        // R10: reset during the write-back of a read-modify-write
        @(negedge clk);
        up_valid = 1'b1; up_write = 1'b1; up_size = 2'd0;
        up_addr = 32'h2200_0090; up_wdata = 32'h1;
        do @(negedge clk); while (!(dn_valid && dn_write));
        rst_n = 1'b0; up_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 dn_valid after mid-flight reset", {31'd0, dn_valid}, 32'd0);
        chk("R10 up_ready after mid-flight reset", {31'd0, up_ready}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 still idle", {31'd0, dn_valid | up_ready}, 32'd0);
        chk("R7 scoreboard drained", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule